// File: doc/BRIEF.md
# Wormhole 2x2 Routing Switch

This block is a single two-input, two-output switching element intended for one stage of a multistage inverted-cube network. Each link is a unidirectional 9-bit path: bits 7:0 carry a data byte and bit 8 carries a parity bit that the switch passes through untouched. Every link uses valid/ready flow control, and every input owns a dedicated FIFO.

A message starts with a four-byte header. Byte 0 holds a 7-bit destination address in bits 6:0. Byte 1 holds the total message length in bytes, header included. The stage is configured by a parameter that picks one bit of the destination address, and that bit alone chooses the output. The switch uses wormhole switching. Once the first byte of a message wins an output, that output stays bound to the input until the byte count taken from byte 1 is reached. Only then can another message claim the output. When two message heads want the same free output in the same cycle, a round-robin choice decides which one goes first. The other head waits in its FIFO.

Top module: `wh_switch2x2`

## Requirements
- R1: After reset both `out_valid` bits are 0 and both `in_ready` bits are 1.
- R2: A message leaves on output `STAGE_BIT`-th bit of its byte 0 (value 0 selects output 0, value 1 selects output 1); with the default `STAGE_BIT` = 0 this is bit 0 of byte 0.
- R3: All 9 bits of every byte, including a wrong parity bit 8, appear on the output unchanged and in arrival order.
- R4: The output stays bound to one input for exactly the number of bytes given in byte 1 (header included). The next message from the same input is then routed on its own byte 0.
- R5: A length field below 4 is treated as 4 bytes, and a length field above 128 is treated as 128 bytes.
- R6: Contention is settled by a round-robin pointer. The pointer favours input 0 after reset, and each grant moves the preference to the other input. Messages are never interleaved on an output, and the losing input's bytes are held in its FIFO.
- R7: Messages from the two inputs to different outputs flow at the same time, so both outputs can transfer in the same cycle.
- R8: Each input FIFO holds 16 bytes. `in_ready` drops when the FIFO is full, and no byte is lost or duplicated.
- R9: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 with the same `out_data`.
- R10: A first byte accepted on an input of an idle switch is presented on its output with `out_valid` = 1 in the cycle right after the accepting clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 2 | Per-input byte valid |
| in_data | input | 2x9 | Per-input byte: bit 8 parity, bits 7:0 data |
| in_ready | output | 2 | Per-input ready (FIFO not full) |
| out_valid | output | 2 | Per-output byte valid |
| out_data | output | 2x9 | Per-output byte, same layout as the inputs |
| out_ready | input | 2 | Per-output downstream ready |

## Verification
A corrupted byte counter in an input tracker shows up at the first message boundary. Either the output is released early and another input's bytes cut into a message, or it is held too long and the next message is stuck behind the expected end. The per-output scoreboard catches both within one message length. A wrong route bit or a wrong arbiter pointer changes the output or the order of a whole message, and this appears on the first byte of that message. A FIFO pointer fault drops, repeats or reorders a byte, and the scoreboard flags the same byte position where it happens.

// File: rtl/wh_sw_pkg.sv
package wh_sw_pkg;
  localparam int DATA_W   = 8;
  localparam int LINK_W   = DATA_W + 1;
  localparam int ADDR_W   = 7;
  localparam int HDR_LEN  = 4;
  localparam int MAX_LEN  = 128;
  localparam int LEN_W    = $clog2(MAX_LEN + 1);
  localparam int IDX_W    = $clog2(MAX_LEN);
  localparam int N_PORT   = 2;

  typedef logic [LINK_W-1:0] flit_t;
endpackage

// File: rtl/wh_fifo.sv
module wh_fifo
  import wh_sw_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  flit_t din,
  output logic  full,
  input  logic  pop,
  output flit_t dout,
  output logic  empty
);
  localparam int AW = $clog2(DEPTH);

  flit_t         mem_q [DEPTH];
  logic [AW:0]   wr_q, wr_d, rd_q, rd_d;
  logic [AW:0]   fill;

  assign fill  = wr_q - rd_q;
  assign full  = (fill == (AW+1)'(DEPTH));
  assign empty = (fill == '0);
  assign dout  = mem_q[rd_q[AW-1:0]];

  always_comb begin
    wr_d = wr_q;
    rd_d = rd_q;
    if (push) wr_d = wr_q + 1'b1;
    if (pop)  rd_d = rd_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_q[AW-1:0]] <= din;
  end

  AST_FIFO_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R8
  AST_FIFO_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= (AW+1)'(DEPTH)); // R8
endmodule

// File: rtl/wh_in_track.sv
module wh_in_track
  import wh_sw_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pop,
  input  flit_t pop_data,
  output logic  at_head,
  output logic  is_last
);
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [LEN_W-1:0] len_clamped;

  always_comb begin
    if (pop_data[DATA_W-1:0] < DATA_W'(HDR_LEN))
      len_clamped = LEN_W'(HDR_LEN);
    else if (pop_data[DATA_W-1:0] > DATA_W'(MAX_LEN))
      len_clamped = LEN_W'(MAX_LEN);
    else
      len_clamped = LEN_W'(pop_data[DATA_W-1:0]);
  end

  assign at_head = (cnt_q == '0);
  assign is_last = (cnt_q >= IDX_W'(2)) &&
                   ({1'b0, cnt_q} == (len_q - LEN_W'(1)));

  always_comb begin
    cnt_d = cnt_q;
    len_d = len_q;
    if (pop) begin
      if (is_last) cnt_d = '0;
      else         cnt_d = cnt_q + 1'b1;
      if (cnt_q == IDX_W'(1)) len_d = len_clamped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= LEN_W'(HDR_LEN);
    end else begin
      cnt_q <= cnt_d;
      len_q <= len_d;
    end
  end

  AST_CNT_WITHIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= IDX_W'(2)) |-> ({1'b0, cnt_q} < len_q)); // R4
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q >= LEN_W'(HDR_LEN)) && (len_q <= LEN_W'(MAX_LEN))); // R5
endmodule

// File: rtl/wh_rr_arb.sv
module wh_rr_arb
  import wh_sw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PORT-1:0] req,
  input  logic              xfer,
  input  logic              xfer_last,
  output logic              active,
  output logic              sel
);
  logic lock_q, lock_d;
  logic owner_q, owner_d;
  logic ptr_q, ptr_d;
  logic pick;

  always_comb begin
    pick = req[ptr_q] ? ptr_q : ~ptr_q;
    if (lock_q) begin
      sel    = owner_q;
      active = 1'b1;
    end else begin
      sel    = pick;
      active = |req;
    end
  end

  always_comb begin
    lock_d  = active && !(xfer && xfer_last);
    owner_d = active ? sel : owner_q;
    ptr_d   = ptr_q;
    if (!lock_q && (|req)) ptr_d = ~pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      owner_q <= 1'b0;
      ptr_q   <= 1'b0;
    end else begin
      lock_q  <= lock_d;
      owner_q <= owner_d;
      ptr_q   <= ptr_d;
    end
  end

  AST_ARB_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !lock_q) |-> req[sel]); // R6
  AST_ARB_NO_STEAL: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !(xfer && xfer_last)) |=> (active && sel == $past(sel))); // R6
endmodule

// File: rtl/wh_switch2x2.sv
module wh_switch2x2
  import wh_sw_pkg::*;
#(
  parameter int STAGE_BIT  = 0,
  parameter int FIFO_DEPTH = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_PORT-1:0]              in_valid,
  input  logic [N_PORT-1:0][LINK_W-1:0]  in_data,
  output logic [N_PORT-1:0]              in_ready,
  output logic [N_PORT-1:0]              out_valid,
  output logic [N_PORT-1:0][LINK_W-1:0]  out_data,
  input  logic [N_PORT-1:0]              out_ready
);
  flit_t             head [N_PORT];
  logic [N_PORT-1:0] empty, full, push, pop, at_head, last;
  logic [N_PORT-1:0] req [N_PORT];
  logic [N_PORT-1:0] active, sel, xfer, xlast;

  for (genvar gi = 0; gi < N_PORT; gi++) begin : g_in
    assign push[gi]     = in_valid[gi] && !full[gi];
    assign in_ready[gi] = !full[gi];

    wh_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push[gi]),
      .din   (in_data[gi]),
      .full  (full[gi]),
      .pop   (pop[gi]),
      .dout  (head[gi]),
      .empty (empty[gi])
    );

    wh_in_track u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .pop      (pop[gi]),
      .pop_data (head[gi]),
      .at_head  (at_head[gi]),
      .is_last  (last[gi])
    );

    AST_READY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_ready[gi]) |-> $past(in_valid[gi])); // R8
  end

  always_comb begin
    for (int o = 0; o < N_PORT; o++) begin
      for (int i = 0; i < N_PORT; i++) begin
        req[o][i] = !empty[i] && at_head[i] &&
                    (head[i][STAGE_BIT] == 1'(o));
      end
    end
  end

  for (genvar go = 0; go < N_PORT; go++) begin : g_out
    wh_rr_arb u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req[go]),
      .xfer      (xfer[go]),
      .xfer_last (xlast[go]),
      .active    (active[go]),
      .sel       (sel[go])
    );

    assign out_valid[go] = active[go] && !empty[sel[go]];
    assign out_data[go]  = head[sel[go]];
    assign xfer[go]      = out_valid[go] && out_ready[go];
    assign xlast[go]     = last[sel[go]];

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[go] && !out_ready[go]) |=>
        (out_valid[go] && $stable(out_data[go]))); // R9
    AST_ROUTE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[go] && at_head[sel[go]]) |->
        (out_data[go][STAGE_BIT] == 1'(go))); // R2
  end

  always_comb begin
    pop = '0;
    for (int o = 0; o < N_PORT; o++) begin
      if (xfer[o]) pop[sel[o]] = 1'b1;
    end
  end

  AST_NO_SHARED_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid[0] && out_valid[1] && (sel[0] == sel[1]))); // R7
  AST_STAGE_BIT_OK: assert property (@(posedge clk) disable iff (!rst_n)
    STAGE_BIT < ADDR_W); // R2
endmodule

// File: tb/wh_switch2x2_tb.sv
`timescale 1ns/1ps
module wh_switch2x2_tb;
  import wh_sw_pkg::*;

  logic                          clk;
  logic                          rst_n;
  logic [N_PORT-1:0]             in_valid;
  logic [N_PORT-1:0][LINK_W-1:0] in_data;
  logic [N_PORT-1:0]             in_ready;
  logic [N_PORT-1:0]             out_valid;
  logic [N_PORT-1:0][LINK_W-1:0] out_data;
  logic [N_PORT-1:0]             out_ready;

  int    total = 0;
  int    bad   = 0;
  string cur_req = "R1";
  bit    both_seen = 0;
  flit_t exp_q [N_PORT][$];

  wh_switch2x2 #(.STAGE_BIT(0), .FIFO_DEPTH(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (out_valid == 2'b11 && out_ready == 2'b11) both_seen = 1;
      for (int o = 0; o < N_PORT; o++) begin
        if (out_valid[o] && out_ready[o]) begin
          if (exp_q[o].size() == 0) begin
            chk(0, cur_req, $sformatf("unexpected flit out%0d", o), out_data[o], 0);
          end else begin
            flit_t e;
            e = exp_q[o].pop_front();
            chk(out_data[o] == e, cur_req, $sformatf("flit out%0d", o), out_data[o], e);
          end
        end
      end
    end
  end

  function automatic void mk(ref flit_t q[$], input logic [7:0] dest,
                             input logic [7:0] lenf, input int n,
                             input logic [7:0] tag);
    q.delete();
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = (k == 0) ? dest : (k == 1) ? lenf : 8'(tag + k);
      q.push_back({~^d, d});
    end
  endfunction

  task automatic expect_on(input int o, input flit_t m[$]);
    foreach (m[k]) exp_q[o].push_back(m[k]);
  endtask

  task automatic send(input int p, input flit_t m[$]);
    foreach (m[k]) begin
      @(negedge clk);
      in_valid[p] = 1'b1;
      in_data[p]  = m[k];
      while (!in_ready[p]) @(negedge clk);
    end
    @(negedge clk);
    in_valid[p] = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    in_valid = '0;
    in_data = '0;
    out_ready = 2'b11;
    exp_q[0].delete();
    exp_q[1].delete();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic drain(input string rq);
    int n;
    n = 0;
    while ((exp_q[0].size() != 0 || exp_q[1].size() != 0) && n < 3000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    chk(exp_q[0].size() == 0, rq, "out0 left over", exp_q[0].size(), 0);
    chk(exp_q[1].size() == 0, rq, "out1 left over", exp_q[1].size(), 0);
    chk(out_valid == 2'b00, rq, "idle after drain", out_valid, 0);
  endtask

  task automatic t_reset();
    cur_req = "R1";
    do_reset();
    chk(out_valid == 2'b00, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 2'b11, "R1", "in_ready after reset", in_ready, 3);
  endtask

  task automatic t_latency();
    flit_t m[$];
    cur_req = "R10";
    do_reset();
    mk(m, 8'h02, 8'd4, 4, 8'h30);
    expect_on(0, m);
    @(negedge clk);
    in_valid[0] = 1'b1;
    in_data[0]  = m[0];
    @(negedge clk);
    chk(out_valid[0] == 1'b1, "R10", "valid one cycle after accept", out_valid[0], 1);
    chk(out_data[0] == m[0], "R10", "first byte data", out_data[0], m[0]);
    for (int k = 1; k < 4; k++) begin
      in_data[0] = m[k];
      @(negedge clk);
    end
    in_valid[0] = 1'b0;
    drain("R10");
  endtask

  task automatic t_route();
    flit_t a[$], b[$];
    cur_req = "R2";
    do_reset();
    mk(a, 8'h10, 8'd6, 6, 8'h40);
    mk(b, 8'h21, 8'd5, 5, 8'h50);
    b[3][8] = ~b[3][8];
    expect_on(0, a);
    expect_on(1, b);
    send(0, a);
    send(0, b);
    drain("R2");
    cur_req = "R3";
    mk(a, 8'h7F, 8'd9, 9, 8'h60);
    a[0][8] = ~a[0][8];
    a[8][8] = ~a[8][8];
    expect_on(1, a);
    send(1, a);
    drain("R3");
  endtask

  task automatic t_length();
    flit_t a[$], b[$], c[$];
    cur_req = "R4";
    do_reset();
    mk(a, 8'h00, 8'd5, 5, 8'h70);
    mk(b, 8'h03, 8'd7, 7, 8'h80);
    mk(c, 8'h04, 8'd6, 6, 8'h90);
    expect_on(0, a);
    expect_on(1, b);
    expect_on(0, c);
    fork
      begin send(0, a); send(0, b); end
      begin repeat (2) @(negedge clk); send(1, c); end
    join
    drain("R4");
  endtask

  task automatic t_clamp();
    flit_t a[$], b[$], c[$];
    cur_req = "R5";
    do_reset();
    mk(a, 8'h00, 8'd2, 4, 8'hA0);
    mk(b, 8'h00, 8'd200, 128, 8'hB0);
    mk(c, 8'h00, 8'd4, 4, 8'hC0);
    expect_on(0, a);
    expect_on(0, b);
    expect_on(0, c);
    send(0, a);
    send(0, b);
    send(0, c);
    drain("R5");
  endtask

  task automatic t_contend();
    flit_t a[$], b[$], c[$];
    cur_req = "R6";
    do_reset();
    mk(a, 8'h08, 8'd6, 6, 8'h10);
    mk(b, 8'h0A, 8'd5, 5, 8'h20);
    mk(c, 8'h0C, 8'd7, 7, 8'h30);
    expect_on(0, a);
    expect_on(0, c);
    expect_on(0, b);
    fork
      begin send(0, a); send(0, b); end
      send(1, c);
    join
    drain("R6");
  endtask

  task automatic t_parallel();
    flit_t a[$], b[$];
    cur_req = "R7";
    do_reset();
    both_seen = 0;
    mk(a, 8'h01, 8'd10, 10, 8'h11);
    mk(b, 8'h02, 8'd10, 10, 8'h22);
    expect_on(1, a);
    expect_on(0, b);
    fork
      send(0, a);
      send(1, b);
    join
    drain("R7");
    chk(both_seen, "R7", "both outputs moved together", both_seen, 1);
  endtask

  task automatic t_backpressure();
    flit_t a[$];
    cur_req = "R8";
    do_reset();
    mk(a, 8'h06, 8'd20, 20, 8'h55);
    expect_on(0, a);
    out_ready[0] = 1'b0;
    fork
      send(0, a);
      begin
        repeat (30) @(negedge clk);
        chk(in_ready[0] == 1'b0, "R8", "in_ready low when full", in_ready[0], 0);
        chk(in_ready[1] == 1'b1, "R8", "other input ready", in_ready[1], 1);
        chk(out_valid[0] == 1'b1, "R9", "valid held under stall", out_valid[0], 1);
        chk(out_data[0] == a[0], "R9", "data held under stall", out_data[0], a[0]);
        @(negedge clk);
        chk(out_valid[0] == 1'b1 && out_data[0] == a[0], "R9",
            "still stable one cycle later", out_data[0], a[0]);
        out_ready[0] = 1'b1;
      end
    join
    drain("R8");
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_route();
    t_length();
    t_clamp();
    t_contend();
    t_parallel();
    t_backpressure();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule